// File: doc/BRIEF.md
# Configuration byte-stream decoder for a single-channel block mover

This block turns a sequence of bytes written to one IO port into the configuration of a single-channel block-transfer engine. Each group starts with a base byte. Fixed bit patterns in that byte select one of seven register groups. Flag bits in the same byte say which parameter bytes follow. The decoder keeps a set of pending parameter slots and consumes them from the lowest flagged slot to the highest. It stores each parameter byte in its field. The command group does not store anything; it produces one-cycle strobes for load, continue, enable and disable. A command can also announce a following read-mask byte.

Bytes arrive on a valid/ready stream. A byte is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and in the first cycle after it. After that it stays high, so the decoder never applies back-pressure, and a producer may hold `in_valid` high for back-to-back bytes. Stored fields change on the clock edge that takes the byte. Command strobes are high for exactly the one cycle after that edge.

Top module: `cfgstream_decoder`

## Requirements
- R1: Reset clears every stored field to 0, drops all pending parameter slots and all strobes, and holds `in_ready` low. The first byte taken after reset is decoded as a base byte, even if reset cut off a group whose parameter bytes had not yet arrived.
- R2: A base byte with bit7=0 and bits1:0 not 00 (codes 01, 10 and 11 behave the same) sets `dir_a_to_b` from bit2. Its flag bits 3, 4, 5 and 6 announce, in that order, the low byte of `a_start`, the high byte of `a_start`, the low byte of `blk_len` and the high byte of `blk_len`. Only flagged bytes follow, in ascending flag order.
- R3: A base byte with bit7=0 and bits2:0=100 configures port A, and one with bits2:0=000 configures port B. In both, bit3 is the IO flag, bits5:4 are stored raw as the address mode (00 decrement, 01 increment, 1x fixed), and bit6 announces a timing byte whose bits1:0 are stored as the cycle code.
- R4: In the port B timing byte, bit5 announces one more byte, which is stored as `prescale`. When bit5 is 0, the next byte is a base byte.
- R5: A base byte with bit7=1 and bits1:0=00 pulses `cmd_enable` when bit6 is 1. Its bit3 and bit4 each announce a byte that is taken and then discarded: it changes no field and causes no strobe.
- R6: A base byte with bit7=1 and bits1:0=01 sets the mode from bits6:5: 10 selects burst (`burst_mode`=1), 01 and 00 select continuous (`burst_mode`=0), and 11 leaves the mode unchanged. Bit2 and bit3 announce the low and high bytes of `b_start`.
- R7: A base byte with bit7=1 and bits1:0=10 sets `ce_wait_mode` from bit4 and `auto_restart` from bit5, but only when bit6=0 and bit2=0. Any other byte of this form is ignored.
- R8: With bit7=1 and bits1:0=11, 0xCF pulses `cmd_load`, 0xD3 pulses `cmd_continue`, 0x87 pulses `cmd_enable`, and 0x83 pulses `cmd_disable`. 0xBB announces one byte that is stored as `read_mask`. Every other code is ignored. At most one strobe is high in any cycle.
- R9: While any parameter slot is pending, every byte taken is a parameter byte, whatever its value, and produces no strobe.
- R10: In a cycle where no byte is taken, no field changes and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The decoder takes the offered byte |
| in_data | input | 8 | Offered byte |
| dir_a_to_b | output | 1 | 1: port A to port B, 0: port B to port A |
| a_is_io | output | 1 | Port A targets IO space |
| a_addr_mode | output | 2 | Port A address mode, raw code |
| a_cycle | output | 2 | Port A cycle code |
| a_start | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| b_is_io | output | 1 | Port B targets IO space |
| b_addr_mode | output | 2 | Port B address mode, raw code |
| b_cycle | output | 2 | Port B cycle code |
| b_start | output | 16 | Port B start address |
| prescale | output | 8 | Fixed-time pacing count |
| burst_mode | output | 1 | 1: burst, 0: continuous |
| ce_wait_mode | output | 1 | Combined chip-enable/wait selected |
| auto_restart | output | 1 | Restart at end of block |
| read_mask | output | 8 | Last read-mask byte |
| cmd_load | output | 1 | One-cycle load strobe |
| cmd_continue | output | 1 | One-cycle continue strobe |
| cmd_enable | output | 1 | One-cycle enable strobe |
| cmd_disable | output | 1 | One-cycle disable strobe |

## Verification
The first group header has all four flags set. A second sets only the outer flags, so the bench can tell ascending-order consumption apart from a fixed slot index. Group headers with every low-bit code of the transfer group and every mode code of the mode group show which codes are aliases and which are ignored. Bytes whose values are also valid commands (0xCF, 0x83) are sent as discarded and read-mask parameters. These show that pending slots take priority over base decoding. The strobe that follows each of them shows that the queue drains back to base decoding. The remaining cases are a reset cut off in the middle of a group and idle cycles with garbage on the data lines.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int BYTE_W = 8;

  // Parameter slots; a lower index is consumed first
  typedef enum logic [3:0] {
    SL_A_LO   = 4'd0,
    SL_A_HI   = 4'd1,
    SL_LEN_LO = 4'd2,
    SL_LEN_HI = 4'd3,
    SL_A_TIM  = 4'd4,
    SL_B_TIM  = 4'd5,
    SL_PRESC  = 4'd6,
    SL_DROP0  = 4'd7,
    SL_DROP1  = 4'd8,
    SL_B_LO   = 4'd9,
    SL_B_HI   = 4'd10,
    SL_RMASK  = 4'd11
  } slot_e;

  localparam int NSLOT   = 12;
  localparam int SLOT_IW = $clog2(NSLOT);

  typedef enum logic [2:0] {
    BK_NONE, BK_XFER, BK_PORTA, BK_PORTB, BK_ENAB, BK_MODE, BK_RSTRT, BK_CMD
  } base_kind_e;

  localparam logic [BYTE_W-1:0] OP_LOAD   = 8'hCF;
  localparam logic [BYTE_W-1:0] OP_CONT   = 8'hD3;
  localparam logic [BYTE_W-1:0] OP_ENABLE = 8'h87;
  localparam logic [BYTE_W-1:0] OP_DISABL = 8'h83;
  localparam logic [BYTE_W-1:0] OP_RMASK  = 8'hBB;
endpackage

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
  import cfgdec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output base_kind_e        kind_o,
  output logic [NSLOT-1:0]  follow_o,
  output logic              op_load_o,
  output logic              op_cont_o,
  output logic              op_en_o,
  output logic              op_dis_o
);
  always_comb begin
    kind_o    = BK_NONE;
    follow_o  = '0;
    op_load_o = 1'b0;
    op_cont_o = 1'b0;
    op_en_o   = 1'b0;
    op_dis_o  = 1'b0;
    if (!byte_i[7]) begin
      if (byte_i[1:0] != 2'b00) begin
        kind_o              = BK_XFER;
        follow_o[SL_A_LO]   = byte_i[3];
        follow_o[SL_A_HI]   = byte_i[4];
        follow_o[SL_LEN_LO] = byte_i[5];
        follow_o[SL_LEN_HI] = byte_i[6];
      end else if (byte_i[2]) begin
        kind_o             = BK_PORTA;
        follow_o[SL_A_TIM] = byte_i[6];
      end else begin
        kind_o             = BK_PORTB;
        follow_o[SL_B_TIM] = byte_i[6];
      end
    end else begin
      case (byte_i[1:0])
        2'b00: begin
          kind_o             = BK_ENAB;
          op_en_o            = byte_i[6];
          follow_o[SL_DROP0] = byte_i[3];
          follow_o[SL_DROP1] = byte_i[4];
        end
        2'b01: begin
          kind_o            = BK_MODE;
          follow_o[SL_B_LO] = byte_i[2];
          follow_o[SL_B_HI] = byte_i[3];
        end
        2'b10: begin
          if (!byte_i[6] && !byte_i[2]) kind_o = BK_RSTRT;
        end
        default: begin
          kind_o = BK_CMD;
          case (byte_i)
            OP_LOAD:   op_load_o = 1'b1;
            OP_CONT:   op_cont_o = 1'b1;
            OP_ENABLE: op_en_o   = 1'b1;
            OP_DISABL: op_dis_o  = 1'b1;
            OP_RMASK:  follow_o[SL_RMASK] = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/cfgdec_pending.sv
module cfgdec_pending #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic [N-1:0]  follow_i,
  input  logic [N-1:0]  extra_i,
  output logic          busy_o,
  output logic [IW-1:0] cur_o
);
  logic [N-1:0] pend_q, pend_d, sel_oh;
  logic [N:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign sel_oh[i]  = pend_q[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | pend_q[i];
  end

  assign busy_o = seen[N];

  always_comb begin
    cur_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_oh[i]) cur_o = cur_o | IW'(i);
  end

  always_comb begin
    pend_d = pend_q;
    if (take_i) begin
      if (busy_o) pend_d = (pend_q & ~sel_oh) | extra_i;
      else        pend_d = follow_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R9: a parameter byte never grows the pending set
  assert_param_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
    (take_i && busy_o) |=> ($countones(pend_q) <= $past($countones(pend_q))));

  // R1: nothing pending right after reset
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0));
endmodule

// File: rtl/cfgdec_regbank.sv
module cfgdec_regbank
  import cfgdec_pkg::*;
#(
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base_i,
  input  base_kind_e        kind_i,
  input  logic              wr_param_i,
  input  slot_e             slot_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              dir_ab_o,
  output logic              a_io_o,
  output logic [1:0]        a_mode_o,
  output logic [1:0]        a_cyc_o,
  output logic [WORD_W-1:0] a_start_o,
  output logic [WORD_W-1:0] len_o,
  output logic              b_io_o,
  output logic [1:0]        b_mode_o,
  output logic [1:0]        b_cyc_o,
  output logic [WORD_W-1:0] b_start_o,
  output logic [BYTE_W-1:0] presc_o,
  output logic              burst_o,
  output logic              cew_o,
  output logic              restart_o,
  output logic [BYTE_W-1:0] rmask_o
);
  localparam int HI = WORD_W - 1;
  localparam int LO = BYTE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_ab_o  <= 1'b0;
      a_io_o    <= 1'b0;
      a_mode_o  <= '0;
      a_cyc_o   <= '0;
      a_start_o <= '0;
      len_o     <= '0;
      b_io_o    <= 1'b0;
      b_mode_o  <= '0;
      b_cyc_o   <= '0;
      b_start_o <= '0;
      presc_o   <= '0;
      burst_o   <= 1'b0;
      cew_o     <= 1'b0;
      restart_o <= 1'b0;
      rmask_o   <= '0;
    end else if (wr_base_i) begin
      case (kind_i)
        BK_XFER:  dir_ab_o <= data_i[2];
        BK_PORTA: begin a_io_o <= data_i[3]; a_mode_o <= data_i[5:4]; end
        BK_PORTB: begin b_io_o <= data_i[3]; b_mode_o <= data_i[5:4]; end
        BK_MODE:  if (data_i[6:5] != 2'b11) burst_o <= (data_i[6:5] == 2'b10);
        BK_RSTRT: begin cew_o <= data_i[4]; restart_o <= data_i[5]; end
        default: ;
      endcase
    end else if (wr_param_i) begin
      case (slot_i)
        SL_A_LO:   a_start_o[LO:0]      <= data_i;
        SL_A_HI:   a_start_o[HI:BYTE_W] <= data_i;
        SL_LEN_LO: len_o[LO:0]          <= data_i;
        SL_LEN_HI: len_o[HI:BYTE_W]     <= data_i;
        SL_A_TIM:  a_cyc_o              <= data_i[1:0];
        SL_B_TIM:  b_cyc_o              <= data_i[1:0];
        SL_PRESC:  presc_o              <= data_i;
        SL_B_LO:   b_start_o[LO:0]      <= data_i;
        SL_B_HI:   b_start_o[HI:BYTE_W] <= data_i;
        SL_RMASK:  rmask_o              <= data_i;
        default: ;
      endcase
    end
  end

  // R10: no write, no change
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_base_i || wr_param_i) |=> ($stable(a_start_o) && $stable(len_o)
      && $stable(b_start_o) && $stable(presc_o) && $stable(rmask_o)));

  // R5: a discarded parameter byte leaves every field alone
  assert_drop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_param_i && !wr_base_i && (slot_i == SL_DROP0 || slot_i == SL_DROP1))
      |=> ($stable(a_start_o) && $stable(len_o) && $stable(b_start_o)
           && $stable(presc_o) && $stable(rmask_o) && $stable(a_cyc_o)
           && $stable(b_cyc_o)));

  // R3: the port A timing byte lands in the cycle code
  assert_a_timing_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_param_i && !wr_base_i && slot_i == SL_A_TIM)
      |=> (a_cyc_o == $past(data_i[1:0])));
endmodule

// File: rtl/cfgstream_decoder.sv
module cfgstream_decoder
  import cfgdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        dir_a_to_b,
  output logic        a_is_io,
  output logic [1:0]  a_addr_mode,
  output logic [1:0]  a_cycle,
  output logic [15:0] a_start,
  output logic [15:0] blk_len,
  output logic        b_is_io,
  output logic [1:0]  b_addr_mode,
  output logic [1:0]  b_cycle,
  output logic [15:0] b_start,
  output logic [7:0]  prescale,
  output logic        burst_mode,
  output logic        ce_wait_mode,
  output logic        auto_restart,
  output logic [7:0]  read_mask,
  output logic        cmd_load,
  output logic        cmd_continue,
  output logic        cmd_enable,
  output logic        cmd_disable
);
  logic               ready_q, accept, busy;
  logic [SLOT_IW-1:0] cur_idx;
  slot_e              cur_slot;
  base_kind_e         kind;
  logic [NSLOT-1:0]   follow, extra;
  logic               op_load, op_cont, op_en, op_dis;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign cur_slot = slot_e'(cur_idx);

  cfgdec_classify u_cls (
    .byte_i(in_data), .kind_o(kind), .follow_o(follow),
    .op_load_o(op_load), .op_cont_o(op_cont), .op_en_o(op_en), .op_dis_o(op_dis)
  );

  // R4: the port B timing byte may queue the pacing byte
  always_comb begin
    extra = '0;
    extra[SL_PRESC] = (cur_slot == SL_B_TIM) && in_data[5];
  end

  cfgdec_pending #(.N(NSLOT), .IW(SLOT_IW)) u_pend (
    .clk(clk), .rst(rst), .take_i(accept), .follow_i(follow),
    .extra_i(extra), .busy_o(busy), .cur_o(cur_idx)
  );

  cfgdec_regbank u_regs (
    .clk(clk), .rst(rst),
    .wr_base_i(accept && !busy), .kind_i(kind),
    .wr_param_i(accept && busy), .slot_i(cur_slot), .data_i(in_data),
    .dir_ab_o(dir_a_to_b), .a_io_o(a_is_io), .a_mode_o(a_addr_mode),
    .a_cyc_o(a_cycle), .a_start_o(a_start), .len_o(blk_len),
    .b_io_o(b_is_io), .b_mode_o(b_addr_mode), .b_cyc_o(b_cycle),
    .b_start_o(b_start), .presc_o(prescale), .burst_o(burst_mode),
    .cew_o(ce_wait_mode), .restart_o(auto_restart), .rmask_o(read_mask)
  );

  always_ff @(posedge clk) begin
    if (rst || !(accept && !busy)) begin
      cmd_load     <= 1'b0;
      cmd_continue <= 1'b0;
      cmd_enable   <= 1'b0;
      cmd_disable  <= 1'b0;
    end else begin
      cmd_load     <= op_load;
      cmd_continue <= op_cont;
      cmd_enable   <= op_en;
      cmd_disable  <= op_dis;
    end
  end

  // R8: strobes are exclusive
  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_load, cmd_continue, cmd_enable, cmd_disable}));

  // R8: a load strobe follows a base 0xCF
  assert_load_origin_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_load |-> $past(accept && !busy && in_data == OP_LOAD));

  // R9: parameter bytes never strobe
  assert_param_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && busy) |=> !(cmd_load || cmd_continue || cmd_enable || cmd_disable));

  // R10: an idle cycle raises no strobe
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !(cmd_load || cmd_continue || cmd_enable || cmd_disable));
endmodule

// File: tb/cfgstream_decoder_bench.sv
module cfgstream_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, dir_a_to_b, a_is_io, b_is_io, burst_mode, ce_wait_mode, auto_restart;
  logic [1:0] a_addr_mode, a_cycle, b_addr_mode, b_cycle;
  logic [15:0] a_start, blk_len, b_start;
  logic [7:0] prescale, read_mask;
  logic cmd_load, cmd_continue, cmd_enable, cmd_disable;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgstream_decoder u_cfgstream_decoder (.*);

  // {req, selector, byte, expected}; selector 0 = no check
  // 1 a_start 2 blk_len 3 b_start 4 prescale 5 {load,cont,en,dis}
  // 6 {a_is_io,a_addr_mode,a_cycle} 7 same for B 8 {dir,burst,cew,restart} 9 read_mask
  localparam int NV = 40;
  localparam logic [31:0] VEC [NV] = '{
    32'h287D0008, 32'h20340000, 32'h21121234, 32'h20100000, 32'h22000010, // R2 all flags
    32'h28490000, 32'h21AB12AB, 32'h22020210,                             // R2 outer flags
    32'h28260008, 32'h22550255,                                           // R2 code 10
    32'h367C001C, 32'h3602001E, 32'h37500004,                             // R3
    32'h47210005, 32'h44800080,                                           // R4 pacing byte
    32'h37400001, 32'h37030003, 32'h45CF0008,                             // R3, R4 none queued
    32'h68AD0008, 32'h60780000, 32'h63565678,                             // R6 B start
    32'h68C1000C, 32'h68810008, 32'h68C1000C, 32'h68E1000C,               // R6 mode codes
    32'h78B2000F, 32'h7882000C, 32'h78C2000C, 32'h7896000C,               // R7
    32'h55C00002, 32'h55980000, 32'h95CF0000, 32'h518312AB, 32'h55830001, // R5, R9
    32'h85D30004, 32'h85870002, 32'h85BB0000, 32'h99CF00CF,               // R8, R9
    32'h858B0000, 32'h85CF0008                                            // R8
  };

  function automatic logic [15:0] observe(input logic [3:0] sel);
    case (sel)
      4'd1: return a_start;
      4'd2: return blk_len;
      4'd3: return b_start;
      4'd4: return {8'h00, prescale};
      4'd5: return {12'h000, cmd_load, cmd_continue, cmd_enable, cmd_disable};
      4'd6: return {11'h000, a_is_io, a_addr_mode, a_cycle};
      4'd7: return {11'h000, b_is_io, b_addr_mode, b_cycle};
      4'd8: return {12'h000, dir_a_to_b, burst_mode, ce_wait_mode, auto_restart};
      4'd9: return {8'h00, read_mask};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ready low in reset", {15'h0, in_ready}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", {15'h0, in_ready}, 16'h0001);
    check("R1 a_start", a_start, 16'h0000);
    check("R1 blk_len", blk_len, 16'h0000);
    check("R1 b_start", b_start, 16'h0000);
    check("R1 misc", observe(4'd8), 16'h0000);
    check("R1 strobes", observe(4'd5), 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wr(v[23:16]);
      if (v[27:24] != 4'd0) begin
        checks++;
        if (observe(v[27:24]) !== v[15:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", v[31:28], i,
                   observe(v[27:24]), v[15:0]);
        end
      end
    end

    // R10: garbage on the data lines with valid low
    @(negedge clk);
    in_data = 8'hCF;
    repeat (3) begin
      @(negedge clk);
      check("R10 idle strobes", observe(4'd5), 16'h0000);
    end
    check("R10 idle a_start", a_start, 16'h12AB);

    // R1: reset in the middle of a group, then a base byte
    wr(8'h79);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 cleared a_start", a_start, 16'h0000);
    @(negedge clk);
    wr(8'h87);
    check("R1 base after reset", observe(4'd5), 16'h0002);
    wr(8'h7F);
    check("R1 hold", observe(4'd8), 16'h0008);

    finish_run();
  end
endmodule